// File: doc/BRIEF.md
# Fixed-Priority Merged Arbiter and Data Selector

This block settles contention among N single-bit requests and, in the same combinational pass, delivers the data word of the winning input at its output. The lowest-numbered active request always wins. There is no state: the request vector and the data buses go in, and the selected word, a flag for whether anything won, and the winner's position come out within the same cycle.

Internally the block is a balanced binary tree of N-1 comparison nodes. Each node forms the larger of its two request values and a direction flag. That flag also steers the data at the node through an AND-OR gate, because every data word is cleared at the leaves unless its own request is set. The same flags build the winner's position in three codings at once. The first is a weighted binary index, built by stacking the flags along the winning path. The second is a onehot vector. The third is a thermometer vector with every bit from position 0 up to the winner set.

It is meant to sit at one output port of a switch. There it performs allocation and traversal together, and the grant it returns to the inputs comes in whichever coding their logic prefers.

Top module: `marx_fixed`

## Requirements
- R1: `any_grant_o` is 1 exactly when at least one bit of `req_i` is 1.
- R2: When any request is active, `grant_bin_o` is the unsigned number of the lowest-indexed active request (bit 0 has the highest priority). For example, with N=8 and `req_i`=8'b01100100, the index is 2.
- R3: When any request is active, `grant_oh_o` has exactly one bit set, at the position given in R2.
- R4: When any request is active, `grant_therm_o` has bits 0 up to and including the winner's position set, and every higher bit clear.
- R5: When any request is active, `data_o` equals the winner's data word, which sits at `data_i[i*DATA_W +: DATA_W]` for input i.
- R6: With no active request, `data_o` is all zeros, `any_grant_o` is 0, `grant_bin_o` is N-1, `grant_oh_o` has only bit N-1 set, and `grant_therm_o` is all ones.
- R7: The data words of inputs that do not win, whether they are requesting or not, have no effect on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | N_IN | Request per input; bit 0 has the highest priority |
| data_i | input | N_IN*DATA_W | Data words, input i at bits i*DATA_W upward |
| data_o | output | DATA_W | Data word of the winning input, zero if none |
| any_grant_o | output | 1 | Some request was granted |
| grant_bin_o | output | $clog2(N_IN) | Winner position, weighted binary |
| grant_oh_o | output | N_IN | Winner position, onehot |
| grant_therm_o | output | N_IN | Winner position, thermometer (bits up to and including winner) |

## Verification
The bench builds the block with its defaults, eight inputs of 32 bits. That keeps the request space small enough to walk all 256 request patterns, so every winner position is reached with every combination of lower- and higher-priority competitors. Each input carries a distinct data word, so a wrong steering decision at any tree level produces a visibly wrong output. Further directed cases cover the all-idle vector, the single-request extremes at positions 0 and 7, and rewrites of the losers' data words while the requests are held.

// File: rtl/marx_pkg.sv
package marx_pkg;

   // true when v is a power of two no smaller than 2
   function automatic bit is_pow2_min2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // side of a leaf under the node h levels above it: 1 = left (upper) half
   function automatic bit leaf_is_left(input int unsigned leaf, input int unsigned h);
      return ((leaf >> (h - 1)) & 1) == 1;
   endfunction

endpackage

// File: rtl/marx_node.sv
module marx_node #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned HEIGHT = 1
) (
   input  logic              req_l,
   input  logic              req_r,
   input  logic [DATA_W-1:0] data_l,
   input  logic [DATA_W-1:0] data_r,
   input  logic [IDX_W-1:0]  idx_l,
   input  logic [IDX_W-1:0]  idx_r,
   output logic              req_o,
   output logic              flag_o,
   output logic [DATA_W-1:0] data_o,
   output logic [IDX_W-1:0]  idx_o
);
   // flag points left whenever the right side is idle
   assign flag_o = ~req_r;
   assign req_o  = req_l | req_r;
   // inputs are pre-masked, so right data is zero whenever the flag is set
   assign data_o = (data_l & {DATA_W{flag_o}}) | data_r;

   always_comb begin
      idx_o             = flag_o ? idx_l : idx_r;
      idx_o[HEIGHT-1]   = flag_o;
   end
endmodule

// File: rtl/marx_grant_expand.sv
module marx_grant_expand
   import marx_pkg::*;
#(
   parameter int unsigned N_IN   = 8,
   parameter int unsigned LVL    = 3
) (
   input  logic [N_IN-1:1] flag_i,
   output logic [N_IN-1:0] oh_o,
   output logic [N_IN-1:0] therm_o
);
   always_comb begin
      for (int i = 0; i < int'(N_IN); i++) begin
         oh_o[i]    = 1'b1;
         therm_o[i] = 1'b1;
         for (int h = 1; h <= int'(LVL); h++) begin
            if (leaf_is_left(i, h)) begin
               oh_o[i]    = oh_o[i]    &  flag_i[(N_IN + i) >> h];
               therm_o[i] = therm_o[i] &  flag_i[(N_IN + i) >> h];
            end else begin
               oh_o[i]    = oh_o[i]    & ~flag_i[(N_IN + i) >> h];
               therm_o[i] = therm_o[i] |  flag_i[(N_IN + i) >> h];
            end
         end
      end
   end
endmodule

// File: rtl/marx_fixed.sv
module marx_fixed
   import marx_pkg::*;
#(
   parameter int unsigned N_IN   = 8,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LVL   = $clog2(N_IN),
   localparam int unsigned NODES = 2 * N_IN
) (
   input  logic [N_IN-1:0]        req_i,
   input  logic [N_IN*DATA_W-1:0] data_i,
   output logic [DATA_W-1:0]      data_o,
   output logic                   any_grant_o,
   output logic [LVL-1:0]         grant_bin_o,
   output logic [N_IN-1:0]        grant_oh_o,
   output logic [N_IN-1:0]        grant_therm_o
);
   if (!is_pow2_min2(N_IN)) begin : g_bad_n
      $error("N_IN must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be at least 1");
   end

   // heap layout: root 1, children 2k (right, lower inputs) and 2k+1 (left)
   logic              n_req  [1:NODES-1];
   logic [DATA_W-1:0] n_data [1:NODES-1];
   logic [LVL-1:0]    n_idx  [1:NODES-1];
   logic [N_IN-1:1]   n_flag;

   for (genvar i = 0; i < N_IN; i++) begin : g_leaf
      assign n_req[N_IN+i]  = req_i[i];
      assign n_data[N_IN+i] = data_i[i*DATA_W +: DATA_W] & {DATA_W{req_i[i]}};
      assign n_idx[N_IN+i]  = '0;
   end

   for (genvar h = 1; h <= LVL; h++) begin : g_lvl
      for (genvar j = 0; j < (N_IN >> h); j++) begin : g_node
         localparam int unsigned K = (N_IN >> h) + j;
         marx_node #(
            .DATA_W(DATA_W),
            .IDX_W (LVL),
            .HEIGHT(h)
         ) u_node (
            .req_l (n_req[2*K+1]),
            .req_r (n_req[2*K]),
            .data_l(n_data[2*K+1]),
            .data_r(n_data[2*K]),
            .idx_l (n_idx[2*K+1]),
            .idx_r (n_idx[2*K]),
            .req_o (n_req[K]),
            .flag_o(n_flag[K]),
            .data_o(n_data[K]),
            .idx_o (n_idx[K])
         );
      end
   end

   marx_grant_expand #(
      .N_IN(N_IN),
      .LVL (LVL)
   ) u_expand (
      .flag_i (n_flag),
      .oh_o   (grant_oh_o),
      .therm_o(grant_therm_o)
   );

   assign any_grant_o = n_req[1];
   assign data_o      = n_data[1];
   assign grant_bin_o = n_idx[1];
endmodule

// File: rtl/marx_fixed_chk.sv
module marx_fixed_chk #(
   parameter int unsigned N_IN   = 8,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LVL   = $clog2(N_IN)
) (
   input logic [N_IN-1:0]        req_i,
   input logic [DATA_W-1:0]      data_o,
   input logic                   any_grant_o,
   input logic [LVL-1:0]         grant_bin_o,
   input logic [N_IN-1:0]        grant_oh_o,
   input logic [N_IN-1:0]        grant_therm_o
);
   logic [N_IN:0] oh_ext;
   logic [N_IN:0] therm_ref;
   assign oh_ext    = {1'b0, grant_oh_o};
   assign therm_ref = (oh_ext << 1) - 1'b1;

   always_comb begin
      if (!$isunknown(req_i)) begin
         a_r1_any_grant: assert (any_grant_o == (req_i != '0));
         a_r3_single_hot: assert ($countones(grant_oh_o) == 1);
         a_r3_bin_agrees: assert (grant_oh_o[grant_bin_o] == 1'b1);
         a_r2_winner_requests: assert (!any_grant_o || ((req_i & grant_oh_o) == grant_oh_o));
         a_r2_no_better_req: assert ((req_i & (grant_oh_o - 1'b1)) == '0);
         a_r4_therm_shape: assert (grant_therm_o == therm_ref[N_IN-1:0]);
         a_r6_idle_zero: assert (any_grant_o || (data_o == '0));
      end
   end
endmodule

bind marx_fixed marx_fixed_chk #(
   .N_IN  (N_IN),
   .DATA_W(DATA_W)
) u_marx_fixed_chk (
   .req_i        (req_i),
   .data_o       (data_o),
   .any_grant_o  (any_grant_o),
   .grant_bin_o  (grant_bin_o),
   .grant_oh_o   (grant_oh_o),
   .grant_therm_o(grant_therm_o)
);

// File: tb/marx_fixed_bench.sv
module marx_fixed_bench;
   localparam int unsigned N_IN       = 8;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned LVL        = $clog2(N_IN);
   localparam time         CLK_PERIOD = 10ns;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [N_IN-1:0]        req;
   logic [N_IN*DATA_W-1:0] dbus;
   logic [DATA_W-1:0]      dout;
   logic                   anyg;
   logic [LVL-1:0]         gbin;
   logic [N_IN-1:0]        goh;
   logic [N_IN-1:0]        gth;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   marx_fixed #(.N_IN(N_IN), .DATA_W(DATA_W)) u_marx_fixed (
      .req_i        (req),
      .data_i       (dbus),
      .data_o       (dout),
      .any_grant_o  (anyg),
      .grant_bin_o  (gbin),
      .grant_oh_o   (goh),
      .grant_therm_o(gth)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s req=%b actual=%0h expected=%0h", tag, req, act, exp);
      end
   endtask

   function automatic int ref_win(input logic [N_IN-1:0] r);
      for (int i = 0; i < int'(N_IN); i++) if (r[i]) return i;
      return -1;
   endfunction

   task automatic load_data(input logic [DATA_W-1:0] seed);
      for (int i = 0; i < int'(N_IN); i++)
         dbus[i*DATA_W +: DATA_W] = seed ^ (DATA_W'(i + 1) * 32'h0101_0101) ^ 32'h5A00_0000;
   endtask

   task automatic apply_and_check(input logic [N_IN-1:0] r);
      int w;
      logic [63:0] e_th;
      @(negedge clk);
      req = r;
      #1;
      w = ref_win(r);
      chk("R1 any_grant", 64'(anyg), 64'(w >= 0));
      if (w >= 0) begin
         e_th = (64'd1 << (w + 1)) - 64'd1;
         chk("R2 bin", 64'(gbin), 64'(w));
         chk("R3 onehot", 64'(goh), 64'd1 << w);
         chk("R4 therm", 64'(gth), e_th);
         chk("R5 data", 64'(dout), 64'(dbus[w*DATA_W +: DATA_W]));
      end else begin
         chk("R6 data", 64'(dout), 64'd0);
         chk("R6 bin", 64'(gbin), 64'(N_IN - 1));
         chk("R6 onehot", 64'(goh), 64'd1 << (N_IN - 1));
         chk("R6 therm", 64'(gth), (64'd1 << N_IN) - 64'd1);
      end
   endtask

   task automatic t_idle;
      load_data(32'h0000_1111);
      apply_and_check('0);   // R6 idle state after reset
   endtask

   task automatic t_example;
      load_data(32'h1234_5678);
      apply_and_check(8'b0110_0100);   // R2 winner must be input 2
      chk("R2 example index", 64'(gbin), 64'd2);
   endtask

   task automatic t_extremes;
      load_data(32'hCAFE_0000);
      apply_and_check(8'b0000_0001);   // R2 top priority alone
      apply_and_check(8'b1000_0000);   // R2 lowest priority alone
      apply_and_check(8'b1111_1111);   // R2 all requesting
   endtask

   task automatic t_exhaustive;
      for (int v = 0; v < (1 << N_IN); v++) begin
         load_data(DATA_W'(v) * 32'h0001_0003);
         apply_and_check(N_IN'(v));   // R1..R6 full sweep
      end
   endtask

   task automatic t_loser_data;
      logic [DATA_W-1:0] keep;
      load_data(32'h0BAD_F00D);
      apply_and_check(8'b1011_1000);   // winner input 3
      keep = dout;
      @(negedge clk);
      for (int i = 0; i < int'(N_IN); i++)
         if (i != 3) dbus[i*DATA_W +: DATA_W] = ~dbus[i*DATA_W +: DATA_W];
      #1;
      chk("R7 loser data ignored", 64'(dout), 64'(keep));
      chk("R7 winner still 3", 64'(gbin), 64'd3);
   endtask

   initial begin
      req  = '0;
      dbus = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_example();
      t_extremes();
      t_exhaustive();
      t_loser_data();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule